// File: doc/BRIEF.md
# Multi-Channel Power and Output Enable Controller

This block decides, for a group of serializer lanes driven from one word clock, which lanes run and which lane drivers float. A master power control gates a shared clock generator. The generator's lock is stood in for by a cycle counter. Each lane also has its own power control, which wakes that lane with a short delay that never disturbs the shared lock. A global driver enable floats every output. Because the enable acts only on the output stage, dropping and raising it brings the lanes back at once, with no re-initialisation.

Each lane gets two registered outputs. The transmit-enable says the lane's serializer is live. The high-impedance flag says its line driver is floating. After a master wake-up, a lane goes live once the shared lock wait and then its own wake wait have both run out. With the defaults (448 + 63) this comes to 512 word clocks.

Top module: `lane_power_ctrl`

## Requirements
- R1: One clock edge after the master power control is sampled low, every transmit-enable is 0 and every high-impedance flag is 1.
- R2: Once the master control and a lane control have both been held high, that lane's transmit-enable first reads 1 after the LOCK_CYC + WAKE_CYC + 1 th edge at which the master is sampled high, and not before.
- R3: One edge after a lane control is sampled low, that lane's transmit-enable is 0 and its high-impedance flag is 1. Other lanes are unchanged.
- R4: With the shared lock held, a lane whose control returns high reads transmit-enable 1 after the WAKE_CYC + 1 th edge at which it is sampled high. No new lock wait is needed.
- R5: A lane's high-impedance flag is 0 only when its transmit-enable is 1 and the driver enable was high at the same edge. A low driver enable floats all lanes one edge later.
- R6: Taking the driver enable low and then high, with the other controls steady, leaves the transmit-enables unchanged. The flags return to 0 one edge after the enable is sampled high.
- R7: After synchronous reset, and while all controls stay low, every transmit-enable is 0 and every high-impedance flag is 1.
- R8: A master control dropped low during the lock wait restarts the wait from zero. The full R2 delay then counts from the edge at which it is sampled high again.
- R9: While the shared lock is not yet reached, the per-lane wake counts are held at zero. A lane raised at any point before lock goes live together with the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous reset, active high |
| master_on_i | input | 1 | Master power control, high = running |
| lane_on_i | input | NCH | Per-lane power control, high = running |
| drive_en_i | input | 1 | Global driver enable, high = drive |
| lane_tx_en_o | output | NCH | Lane serializer live (registered) |
| lane_hiz_o | output | NCH | Lane driver floating (registered) |

## Verification
A lock counter that runs early or late moves the rising edge of every transmit-enable by the same number of cycles. So does one that fails to clear on a master drop. The bench's model flags that at the first cycle of difference, about 500 cycles after wake-up. A wake counter that is not held during the lock wait, or not cleared by a lane drop, shows up as one lane going live out of step with its neighbours. Because the flags are registered, a wrong driver-enable path shows on the floating flags exactly one edge after the enable changes.

// File: rtl/lpc_pkg.sv
package lpc_pkg;

  typedef enum logic [1:0] {
    LN_ASLEEP = 2'd0,
    LN_WAKING = 2'd1,
    LN_LIVE   = 2'd2
  } lane_state_e;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/lpc_lock_timer.sv
module lpc_lock_timer #(
  parameter int unsigned LOCK_CYC = 448
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic locked_o
);
  localparam int unsigned W = lpc_pkg::cnt_width(LOCK_CYC);
  localparam logic [W-1:0] LAST = W'(LOCK_CYC - 1);

  logic [W-1:0] cnt_q;
  logic         locked_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt_q    <= '0;
      locked_q <= 1'b0;
    end else if (!locked_q) begin
      if (cnt_q == LAST) locked_q <= 1'b1;
      else               cnt_q    <= cnt_q + 1'b1;
    end
  end

  assign locked_o = locked_q;
endmodule

// File: rtl/lpc_lane_wake.sv
module lpc_lane_wake #(
  parameter int unsigned WAKE_CYC = 63
) (
  input  logic clk,
  input  logic rst,
  input  logic enable_i,
  output logic live_o
);
  import lpc_pkg::*;
  localparam int unsigned W = cnt_width(WAKE_CYC);
  localparam logic [W-1:0] LAST = W'(WAKE_CYC - 1);

  lane_state_e st_q;
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !enable_i) begin
      st_q  <= LN_ASLEEP;
      cnt_q <= '0;
    end else begin
      case (st_q)
        LN_ASLEEP: begin
          if (WAKE_CYC <= 1) st_q <= LN_LIVE;
          else begin
            st_q  <= LN_WAKING;
            cnt_q <= W'(1);
          end
        end
        LN_WAKING: begin
          if (cnt_q == LAST) st_q  <= LN_LIVE;
          else               cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= LN_LIVE;
      endcase
    end
  end

  assign live_o = (st_q == LN_LIVE);
endmodule

// File: rtl/lpc_out_stage.sv
module lpc_out_stage #(
  parameter int unsigned NCH = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           drive_en_i,
  input  logic [NCH-1:0] gate_i,
  output logic [NCH-1:0] tx_en_o,
  output logic [NCH-1:0] hiz_o
);
  for (genvar i = 0; i < NCH; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        tx_en_o[i] <= 1'b0;
        hiz_o[i]   <= 1'b1;
      end else begin
        tx_en_o[i] <= gate_i[i];
        hiz_o[i]   <= !(gate_i[i] && drive_en_i);
      end
    end
  end
endmodule

// File: rtl/lane_power_ctrl.sv
module lane_power_ctrl #(
  parameter int unsigned NCH      = 8,
  parameter int unsigned LOCK_CYC = 448,
  parameter int unsigned WAKE_CYC = 63
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           master_on_i,
  input  logic [NCH-1:0] lane_on_i,
  input  logic           drive_en_i,
  output logic [NCH-1:0] lane_tx_en_o,
  output logic [NCH-1:0] lane_hiz_o
);
  logic           lock_done;
  logic [NCH-1:0] lane_live;
  logic [NCH-1:0] lane_gate;

  lpc_lock_timer #(.LOCK_CYC(LOCK_CYC)) u_lock (
    .clk      (clk),
    .rst      (rst),
    .run_i    (master_on_i),
    .locked_o (lock_done)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_wake
    lpc_lane_wake #(.WAKE_CYC(WAKE_CYC)) u_wake (
      .clk      (clk),
      .rst      (rst),
      .enable_i (master_on_i && lane_on_i[i] && lock_done),
      .live_o   (lane_live[i])
    );
    assign lane_gate[i] = master_on_i && lane_on_i[i] && lane_live[i];
  end

  lpc_out_stage #(.NCH(NCH)) u_out (
    .clk        (clk),
    .rst        (rst),
    .drive_en_i (drive_en_i),
    .gate_i     (lane_gate),
    .tx_en_o    (lane_tx_en_o),
    .hiz_o      (lane_hiz_o)
  );
endmodule

// File: rtl/lane_power_ctrl_chk.sv
module lane_power_ctrl_chk #(
  parameter int unsigned NCH      = 8,
  parameter int unsigned LOCK_CYC = 448,
  parameter int unsigned WAKE_CYC = 63
) (
  input logic           clk,
  input logic           rst,
  input logic           master_on_i,
  input logic [NCH-1:0] lane_on_i,
  input logic           drive_en_i,
  input logic [NCH-1:0] lane_tx_en_o,
  input logic [NCH-1:0] lane_hiz_o,
  input logic           lock_done
);
  localparam logic [31:0] LIMIT = 32'(LOCK_CYC + WAKE_CYC + 1);
  logic [31:0] streak;

  always_ff @(posedge clk) begin
    if (rst || !master_on_i) streak <= '0;
    else if (streak < LIMIT) streak <= streak + 1;
  end

  AST_MASTER_OFF: assert property (@(posedge clk) disable iff (rst)
    !master_on_i |=> (lane_tx_en_o == '0 && &lane_hiz_o)); // R1
  AST_LOCK_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (|lane_tx_en_o) |-> (streak >= LIMIT)); // R2
  AST_DRIVER_OFF: assert property (@(posedge clk) disable iff (rst)
    !drive_en_i |=> &lane_hiz_o); // R5
  AST_TX_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (|lane_tx_en_o) |-> lock_done); // R9

  for (genvar i = 0; i < NCH; i++) begin : g_lane
    AST_LANE_OFF: assert property (@(posedge clk) disable iff (rst)
      !lane_on_i[i] |=> (!lane_tx_en_o[i] && lane_hiz_o[i])); // R3
    AST_DRIVE_NEEDS_TX: assert property (@(posedge clk) disable iff (rst)
      !lane_hiz_o[i] |-> lane_tx_en_o[i]); // R5
  end
endmodule

bind lane_power_ctrl lane_power_ctrl_chk #(
  .NCH(NCH), .LOCK_CYC(LOCK_CYC), .WAKE_CYC(WAKE_CYC)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .master_on_i  (master_on_i),
  .lane_on_i    (lane_on_i),
  .drive_en_i   (drive_en_i),
  .lane_tx_en_o (lane_tx_en_o),
  .lane_hiz_o   (lane_hiz_o),
  .lock_done    (lock_done)
);

// File: tb/lane_power_ctrl_tb.sv
module lane_power_ctrl_tb;
  localparam int NCH = 8;
  localparam int LOCK = 448;
  localparam int WAKE = 63;
  localparam int TOTAL = LOCK + WAKE + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mst = 1'b0;
  logic [NCH-1:0] lanes = '0;
  logic drv = 1'b0;
  logic [NCH-1:0] tx, hiz;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lane_power_ctrl #(.NCH(NCH), .LOCK_CYC(LOCK), .WAKE_CYC(WAKE)) u_dut (
    .clk(clk), .rst(rst), .master_on_i(mst), .lane_on_i(lanes),
    .drive_en_i(drv), .lane_tx_en_o(tx), .lane_hiz_o(hiz)
  );

  // Behavioural reference: streak lengths of qualifying samples
  int m_run;
  int l_run [NCH];
  logic [NCH-1:0] exp_tx = '0;
  logic [NCH-1:0] exp_hiz = '1;

  always @(posedge clk) begin
    if (rst) begin
      m_run = 0;
      for (int i = 0; i < NCH; i++) l_run[i] = 0;
      exp_tx = '0;
      exp_hiz = '1;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        exp_tx[i]  = mst && lanes[i] && (l_run[i] >= WAKE);
        exp_hiz[i] = !(exp_tx[i] && drv);
      end
      for (int i = 0; i < NCH; i++)
        l_run[i] = (mst && lanes[i] && m_run >= LOCK) ? ((l_run[i] < WAKE) ? l_run[i] + 1 : WAKE) : 0;
      m_run = mst ? ((m_run < LOCK) ? m_run + 1 : LOCK) : 0;
    end
  end

  task automatic chk(input string tag, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2 model tx", tx, exp_tx);
      chk("R5 model hiz", hiz, exp_hiz);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
      $finish;
    end
  end

  task automatic wait_n(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    wait_n(3);
    rst = 1'b0;
    @(negedge clk);
    chk("R7 reset tx", tx, '0);
    chk("R7 reset hiz", hiz, '1);
    wait_n(20);
    chk("R7 idle tx", tx, '0);
    chk("R7 idle hiz", hiz, '1);

    // Master wake with all lanes and drivers on
    mst = 1'b1; lanes = '1; drv = 1'b1;
    wait_n(TOTAL - 1);
    chk("R2 before lock tx", tx, '0);
    wait_n(1);
    chk("R2 live tx", tx, '1);
    chk("R2 live hiz", hiz, '0);

    // Driver enable off and back on
    drv = 1'b0;
    wait_n(1);
    chk("R5 float hiz", hiz, '1);
    chk("R6 tx kept", tx, '1);
    wait_n(10);
    drv = 1'b1;
    wait_n(1);
    chk("R6 restore hiz", hiz, '0);
    chk("R6 restore tx", tx, '1);

    // Single lane sleep and wake
    lanes[3] = 1'b0;
    wait_n(1);
    chk("R3 lane off tx", tx, 8'hF7);
    chk("R3 lane off hiz", hiz, 8'h08);
    wait_n(5);
    lanes[3] = 1'b1;
    wait_n(WAKE);
    chk("R4 lane waking tx", tx, 8'hF7);
    wait_n(1);
    chk("R4 lane back tx", tx, 8'hFF);

    // Master off
    mst = 1'b0;
    wait_n(1);
    chk("R1 master off tx", tx, '0);
    chk("R1 master off hiz", hiz, '1);

    // Lock wait interrupted, then restarted
    mst = 1'b1;
    wait_n(300);
    mst = 1'b0;
    wait_n(1);
    mst = 1'b1;
    wait_n(TOTAL - 1);
    chk("R8 restart pending tx", tx, '0);
    wait_n(1);
    chk("R8 restart live tx", tx, '1);

    // Lane raised partway through the lock wait
    mst = 1'b0;
    wait_n(2);
    mst = 1'b1; lanes[2] = 1'b0;
    for (int k = 1; k < TOTAL; k++) begin
      @(negedge clk);
      if (k == 300) lanes[2] = 1'b1;
    end
    chk("R9 pending tx", tx, '0);
    wait_n(1);
    chk("R9 lanes together tx", tx, '1);

    wait_n(4);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
    $finish;
  end
endmodule